// File: doc/BRIEF.md
# Run-of-Three-Ones Detector

This block watches a serial bit stream, taking one bit on `x` at each rising clock edge. It raises its flag `y` once three or more 1s have arrived back to back. A single 0 anywhere clears the count. The machine has four states on two state bits, A and B. These count the current run of 1s and stop counting at three: a longer run leaves the machine in the top state.

The output can be built in two ways, chosen by the parameter `OUT_KIND`. The default is a registered-state (Moore) decode, in which `y` depends only on the state. `y` is then high in the cycle after the third 1 and stays high while 1s keep arriving. The other choice is an input-qualified (Mealy) decode, in which `y` is raised combinationally in the same cycle the third 1 is present on `x`.

Both next-state bits come from fixed sum-of-minterm masks over (A, B, x), evaluated by a generic minterm evaluator. The state bits are brought out on ports so that the surrounding logic, and the bench, can see them.

Top module: `run3_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts AB into 00 (state S0). In the Moore build `y` then reads 0.
- R2: When `x` is 0 at a rising edge and reset is low, AB becomes 00 at that edge, whatever the present state.
- R3: When `x` is 1 at a rising edge, the state steps forward by one. The encodings are S0=00, S1=01, S2=10 and S3=11, with A as the upper bit.
- R4: When `x` is 1 at a rising edge in S3 (AB=11), the state stays at S3.
- R5: In the Moore build (`OUT_KIND` = 0), `y` is 1 exactly when AB = 11.
- R6: In the Mealy build (`OUT_KIND` = 1), `y` equals `x` AND A with no register in the path. `y` therefore goes high in the same cycle that the third consecutive 1 is on `x`.
- R7: In the Mealy build, `y` is 0 whenever `x` is 0, even while the state is S3.
- R8: Reset takes priority over `x`: with `rst` high and `x` high, the next state is still S0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit, one per clock |
| y | output | 1 | Flag: a run of three or more 1s |
| state_a | output | 1 | State bit A (upper) |
| state_b | output | 1 | State bit B (lower) |

## Verification
The case that is hardest to reach is the difference between the two output forms at the boundaries of a run. Examples are the cycle in which the third 1 is present while the state is still S2, and the cycle in which a 0 arrives while the state is S3. The bench runs a Moore instance and a Mealy instance side by side on the same stream. That stream has runs of every length from one to seven, as well as alternating bits. Reset is also asserted in the middle of a long run while `x` is held high, so that the saturated state is cut by reset and not by a 0.

// File: rtl/run3_pkg.sv
package run3_pkg;
   localparam int STATE_W = 2;
   localparam int EVAL_IN = STATE_W + 1;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_ONE   = 2'b01,
      ST_TWO   = 2'b10,
      ST_SAT   = 2'b11
   } run_state_e;

   // Minterm masks over the index {A, B, x}
   localparam logic [7:0] NEXT_A_MASK = 8'b1010_1000; // m3, m5, m7
   localparam logic [7:0] NEXT_B_MASK = 8'b1010_0010; // m1, m5, m7
endpackage

// File: rtl/minterm_eval.sv
module minterm_eval #(
   parameter int                   N_IN = 3,
   parameter logic [(1<<N_IN)-1:0] MASK = '0
) (
   input  logic [N_IN-1:0] sel,
   output logic            f
);
   localparam int N_TERMS = 1 << N_IN;

   if (N_IN < 1 || N_IN > 6) begin : g_bad_width
      initial $error("minterm_eval: N_IN out of supported range");
   end

   logic [N_TERMS-1:0] hit;
   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      if (MASK[t]) begin : g_on
         assign hit[t] = (sel == N_IN'(t));
      end else begin : g_off
         assign hit[t] = 1'b0;
      end
   end

   assign f = |hit;
endmodule

// File: rtl/run3_state_reg.sv
module run3_state_reg
   import run3_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               x,
   output logic [STATE_W-1:0] ab
);
   logic               nxt_a, nxt_b;
   logic [EVAL_IN-1:0] idx;

   assign idx = {ab, x};

   minterm_eval #(.N_IN(EVAL_IN), .MASK(NEXT_A_MASK)) u_eval_a (
      .sel (idx),
      .f   (nxt_a)
   );
   minterm_eval #(.N_IN(EVAL_IN), .MASK(NEXT_B_MASK)) u_eval_b (
      .sel (idx),
      .f   (nxt_b)
   );

   always_ff @(posedge clk) begin
      if (rst) ab <= ST_IDLE;
      else     ab <= {nxt_a, nxt_b};
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> ab == ST_IDLE);
   assert_zero_clears_R2: assert property (@(posedge clk) disable iff (rst)
      !x |=> ab == ST_IDLE);
   assert_one_steps_R3: assert property (@(posedge clk) disable iff (rst)
      (x && ab != ST_SAT) |=> ab == $past(ab) + 2'd1);
   assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
      (x && ab == ST_SAT) |=> ab == ST_SAT);
   assert_reset_wins_R8: assert property (@(posedge clk)
      (rst && x) |=> ab == ST_IDLE);
endmodule

// File: rtl/run3_out_decode.sv
module run3_out_decode
   import run3_pkg::*;
#(
   parameter int OUT_KIND = 0
) (
   input  logic               x,
   input  logic [STATE_W-1:0] ab,
   output logic               y
);
   if (OUT_KIND == 0) begin : g_moore
      assign y = ab[1] & ab[0];
   end else if (OUT_KIND == 1) begin : g_mealy
      assign y = x & ab[1];
   end else begin : g_bad_kind
      initial $error("run3_out_decode: OUT_KIND must be 0 or 1");
      assign y = 1'b0;
   end
endmodule

// File: rtl/run3_detector.sv
module run3_detector
   import run3_pkg::*;
#(
   parameter int OUT_KIND = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   output logic y,
   output logic state_a,
   output logic state_b
);
   logic [STATE_W-1:0] ab;

   run3_state_reg u_state (
      .clk (clk),
      .rst (rst),
      .x   (x),
      .ab  (ab)
   );

   run3_out_decode #(.OUT_KIND(OUT_KIND)) u_out (
      .x  (x),
      .ab (ab),
      .y  (y)
   );

   assign state_a = ab[1];
   assign state_b = ab[0];

   if (OUT_KIND == 0) begin : g_chk_moore
      // R5: a raised flag needs a 1 on the previous edge out of S2 or S3
      assert_flag_history_R5: assert property (@(posedge clk) disable iff (rst)
         y |-> ($past(x) && $past(state_a)));
   end else begin : g_chk_mealy
      assert_flag_needs_x_R7: assert property (@(posedge clk) disable iff (rst)
         !x |-> !y);
      // R6: flag high means at least two 1s arrived before this one
      assert_flag_on_third_R6: assert property (@(posedge clk) disable iff (rst)
         y |-> $past(x));
   end
endmodule

// File: tb/run3_detector_tb.sv
module run3_detector_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic y_mo, a_mo, b_mo;
   logic y_me, a_me, b_me;

   int checks = 0;
   int fails  = 0;
   int run    = 0;     // model: consecutive 1s seen, capped at 3
   bit model_ok = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   run3_detector #(.OUT_KIND(0)) u_dut (
      .clk(clk), .rst(rst), .x(x), .y(y_mo), .state_a(a_mo), .state_b(b_mo));
   run3_detector #(.OUT_KIND(1)) u_dut_mealy (
      .clk(clk), .rst(rst), .x(x), .y(y_me), .state_a(a_me), .state_b(b_me));

   string st_tag = "R1";

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // apply one bit: drive at negedge, check, then let the edge update the model
   task automatic step(input bit r, input bit v);
      int exp_ab;
      @(negedge clk);
      rst = r;
      x   = v;
      #0.5;
      if (model_ok) begin
         exp_ab = run;  // 0..3 maps to 00,01,10,11
         chk({st_tag, " moore state"}, {a_mo, b_mo}, exp_ab);
         chk({st_tag, " mealy state"}, {a_me, b_me}, exp_ab);
         chk("R5 moore flag", y_mo, (run == 3) ? 1 : 0);
         if (v) chk("R6 mealy flag", y_me, (run >= 2) ? 1 : 0);
         else   chk("R7 mealy flag with x=0", y_me, 0);
      end
      @(posedge clk);
      if (r)           begin st_tag = v ? "R8" : "R1"; run = 0; end
      else if (!v)     begin st_tag = "R2"; run = 0; end
      else if (run==3) begin st_tag = "R4"; end
      else             begin st_tag = "R3"; run = run + 1; end
      model_ok = 1;
   endtask

   task automatic burst(input int len);
      for (int i = 0; i < len; i++) step(0, 1);
      step(0, 0);
   endtask

   initial begin
      step(1, 0);
      step(1, 1);          // R8: reset wins over x=1
      step(0, 0);
      for (int n = 1; n <= 7; n++) burst(n);
      for (int i = 0; i < 12; i++) step(0, i[0]);
      for (int i = 0; i < 5; i++) step(0, 1);
      step(1, 1);          // R8: reset mid-run with x high
      step(0, 1);
      step(0, 1);
      step(0, 1);
      step(0, 1);
      step(0, 0);
      step(0, 0);
      for (int i = 0; i < 40; i++) step(0, ((i * 7 + 3) % 5) != 0);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule